// File: doc/BRIEF.md
# Boot Mirror Preloader

This block runs the start-up sequence of a processor accelerator board. From system reset onward it keeps the board's original processor held in reset. It reads a ROM image one word at a time over the slow system bus, using a request/acknowledge handshake, and writes each word into the fast local mirror memory. The mirror has no per-entry valid tracking, so every word of the image has to be in place before the accelerated processor runs. The accelerated processor's reset is therefore released only after the last word has been written.

The memory map can move during boot, so the source base address on the slow bus and the destination base address in the mirror are inputs and are not fixed in the logic. The copy length in words is a parameter. A system reset at any point, including the middle of the copy, starts the sequence again from the first word.

Top module: `boot_mirror_loader`

## Requirements
- R1: `origCpuRst` is high, holding the original processor in reset, from the first clock after reset and at every later cycle.
- R2: Word i (i = 0 .. COPY_WORDS-1) is requested at bus address `srcBase + i`. The words are requested in ascending order, and the first request follows reset.
- R3: When word i is acknowledged, exactly one mirror write follows. `mirWe` is high for one cycle, starting the cycle after the acknowledge is accepted, with `mirAddr = dstBase + i` and `mirData` equal to `busData` as sampled with the acknowledge.
- R4: `busReq` stays high until `busAck` is seen, however long that takes. The block never writes to the mirror for a word that has not been acknowledged.
- R5: After exactly COPY_WORDS mirror writes, `copyDone` goes high. It then stays high until the next reset, and no further bus requests or mirror writes occur.
- R6: `fastRstN` is low while the copy runs. It goes high exactly one cycle after `copyDone` rises and stays high until a system reset.
- R7: A reset (`rstN` low) during the copy returns `copyDone` and `fastRstN` to low and drops `busReq`. After the reset is released, the copy starts again from word 0.
- R8: A `busAck` pulse while `busReq` is low has no effect. It produces no mirror write and no change to `copyDone`.
- R9: Source and destination addresses are computed modulo 2^ADDR_W, so a copy that runs past the top of the address space wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| srcBase | input | ADDR_W | ROM image base address on the slow bus |
| dstBase | input | ADDR_W | Base address of the image in the mirror |
| busReq | output | 1 | Slow-bus read request |
| busAddr | output | ADDR_W | Slow-bus read address |
| busAck | input | 1 | Slow-bus acknowledge; `busData` is valid with it |
| busData | input | DATA_W | Slow-bus read data |
| mirWe | output | 1 | Mirror write strobe |
| mirAddr | output | ADDR_W | Mirror write address |
| mirData | output | DATA_W | Mirror write data |
| origCpuRst | output | 1 | Active-high reset to the original processor |
| fastRstN | output | 1 | Active-low reset to the accelerated processor |
| copyDone | output | 1 | The copy is complete |

## Verification
The copy is run with three acknowledge timing patterns. With zero-wait acknowledges, an acknowledge accepted in the first request cycle is tested. With a fixed two-cycle wait, the request is shown to be held. With a wait that varies from word to word, any link between the word counter and the handshake timing would show up. The base pairs include one that crosses the top of the address space, which separates modulo addressing from a carry into a wider sum. A reset after a few words, with a different wait pattern, shows whether the counter restarts or resumes. Acknowledge pulses after completion check that the finished state cannot be disturbed.

// File: rtl/boot_mirror_pkg.sv
package boot_mirror_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COPY_REQ,
    ST_COPY_WAIT,
    ST_NEXT,
    ST_DONE
  } loadState_t;

  typedef struct packed {
    logic clearIndex;
    logic advanceIndex;
    logic captureWord;
  } dpStrobe_t;

endpackage

// File: rtl/boot_mirror_ctrl.sv
module boot_mirror_ctrl
  import boot_mirror_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busAck,
  input  logic      lastWord,
  output dpStrobe_t strb,
  output logic      busReq,
  output logic      copyDone,
  output logic      fastRstN,
  output logic      origCpuRst
);

  loadState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        strb.clearIndex = 1'b1;
        stateNext       = ST_COPY_REQ;
      end
      ST_COPY_REQ, ST_COPY_WAIT: begin
        if (busAck) begin
          strb.captureWord = 1'b1;
          stateNext        = ST_NEXT;
        end else begin
          stateNext = ST_COPY_WAIT;
        end
      end
      ST_NEXT: begin
        if (lastWord) begin
          stateNext = ST_DONE;
        end else begin
          strb.advanceIndex = 1'b1;
          stateNext         = ST_COPY_REQ;
        end
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busReq   = (state == ST_COPY_REQ) || (state == ST_COPY_WAIT);
  assign copyDone = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastRstN   <= 1'b0;
      origCpuRst <= 1'b1;
    end else begin
      origCpuRst <= 1'b1;
      if (copyDone) fastRstN <= 1'b1;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busReq);

  // R5
  done_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    copyDone |=> copyDone);

  // R5
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    copyDone |-> !busReq);

  // R6
  fast_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(copyDone) |=> $rose(fastRstN));

  // R6
  fast_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastRstN |=> fastRstN);

  // R6
  fast_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !copyDone |-> !fastRstN);

endmodule

// File: rtl/boot_mirror_dp.sv
module boot_mirror_dp
  import boot_mirror_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int COPY_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              lastWord,
  output logic              mirWe,
  output logic [ADDR_W-1:0] mirAddr,
  output logic [DATA_W-1:0] mirData
);

  localparam int IDX_W = (COPY_WORDS > 1) ? $clog2(COPY_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COPY_WORDS - 1);

  logic [IDX_W-1:0]  wordIdx;
  logic [ADDR_W-1:0] idxWide;

  assign idxWide  = ADDR_W'(wordIdx);
  assign busAddr  = srcBase + idxWide;
  assign lastWord = (wordIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
    end else if (strb.clearIndex) begin
      wordIdx <= '0;
    end else if (strb.advanceIndex) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mirWe   <= 1'b0;
      mirAddr <= '0;
      mirData <= '0;
    end else begin
      mirWe <= strb.captureWord;
      if (strb.captureWord) begin
        mirAddr <= dstBase + idxWide;
        mirData <= busData;
      end
    end
  end

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordIdx <= LAST_IDX);

  // R3
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    mirWe |=> !mirWe);

endmodule

// File: rtl/boot_mirror_loader.sv
module boot_mirror_loader
  import boot_mirror_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int COPY_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busData,
  output logic              mirWe,
  output logic [ADDR_W-1:0] mirAddr,
  output logic [DATA_W-1:0] mirData,
  output logic              origCpuRst,
  output logic              fastRstN,
  output logic              copyDone
);

  dpStrobe_t strb;
  logic      lastWord;

  boot_mirror_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAck     (busAck),
    .lastWord   (lastWord),
    .strb       (strb),
    .busReq     (busReq),
    .copyDone   (copyDone),
    .fastRstN   (fastRstN),
    .origCpuRst (origCpuRst)
  );

  boot_mirror_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .COPY_WORDS (COPY_WORDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcBase  (srcBase),
    .dstBase  (dstBase),
    .busData  (busData),
    .busAddr  (busAddr),
    .lastWord (lastWord),
    .mirWe    (mirWe),
    .mirAddr  (mirAddr),
    .mirData  (mirData)
  );

  // R1
  orig_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    origCpuRst);

  // R3
  write_follows_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck) |=> mirWe);

  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReq && !mirWe) |=> !mirWe);

endmodule

// File: tb/sim_boot_mirror_loader.sv
module sim_boot_mirror_loader;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int COPY_WORDS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] srcBase = '0, dstBase = '0;
  logic busReq, busAck = 1'b0;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData = '0;
  logic mirWe, origCpuRst, fastRstN, copyDone;
  logic [ADDR_W-1:0] mirAddr;
  logic [DATA_W-1:0] mirData;

  int checks = 0, errors = 0, cycles = 0;
  int latMode = 0, expIdx = 0, waitCnt = 0;
  bit ackPoke = 1'b0;
  bit monOn = 1'b0;
  bit reqSeen = 1'b0;

  boot_mirror_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COPY_WORDS(COPY_WORDS)) u0 (
    .clk(clk), .rstN(rstN), .srcBase(srcBase), .dstBase(dstBase),
    .busReq(busReq), .busAddr(busAddr), .busAck(busAck), .busData(busData),
    .mirWe(mirWe), .mirAddr(mirAddr), .mirData(mirData),
    .origCpuRst(origCpuRst), .fastRstN(fastRstN), .copyDone(copyDone));

  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] romWord(input logic [ADDR_W-1:0] a);
    return DATA_W'((a * 16'd37) ^ 16'h5A3C);
  endfunction

  function automatic int waitFor(input int idx);
    if (latMode == 0) return 0;
    if (latMode == 1) return 2;
    return (idx * 3) % 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slow-bus responder
  initial forever begin
    @(negedge clk);
    if (ackPoke) begin
      busAck = 1'b1;
    end else if (!busReq || !rstN) begin
      busAck = 1'b0;
      waitCnt = 0;
    end else begin
      if (waitCnt >= waitFor(int'(ADDR_W'(busAddr - srcBase)))) begin
        busAck = 1'b1;
        busData = romWord(busAddr);
      end else begin
        busAck = 1'b0;
      end
      waitCnt++;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (monOn && rstN) begin
      if (busReq && !reqSeen) begin
        // R2 and R9: request address follows srcBase + index, modulo
        chk(busAddr == ADDR_W'(srcBase + expIdx), "R2 request address", busAddr, ADDR_W'(srcBase + expIdx));
      end
      reqSeen = busReq;
      if (mirWe) begin
        // R3 and R9
        chk(mirAddr == ADDR_W'(dstBase + expIdx), "R3 mirror address", mirAddr, ADDR_W'(dstBase + expIdx));
        chk(mirData == romWord(ADDR_W'(srcBase + expIdx)), "R3 mirror data", mirData, romWord(ADDR_W'(srcBase + expIdx)));
        expIdx++;
      end
      if (!origCpuRst) chk(1'b0, "R1 original cpu reset", origCpuRst, 1);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    monOn = 1'b0;
    repeat (2) @(negedge clk);
    // R7: reset values
    chk(copyDone == 1'b0, "R7 done in reset", copyDone, 0);
    chk(fastRstN == 1'b0, "R7 fast reset in reset", fastRstN, 0);
    chk(busReq == 1'b0, "R7 request in reset", busReq, 0);
    expIdx = 0;
    reqSeen = 1'b0;
    monOn = 1'b1;
    rstN = 1'b1;
  endtask

  task automatic runCopy(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d, input int mode);
    int guard;
    srcBase = s; dstBase = d; latMode = mode;
    doReset();
    guard = 0;
    while (!copyDone && guard < 1000) begin
      @(negedge clk);
      // R6: accelerated cpu held while copying
      if (!copyDone) chk(fastRstN == 1'b0, "R6 fast reset during copy", fastRstN, 0);
      guard++;
    end
    chk(copyDone == 1'b1, "R5 done reached", copyDone, 1);
    chk(fastRstN == 1'b0, "R6 fast reset at done rise", fastRstN, 0);
    chk(expIdx == COPY_WORDS, "R5 write count", expIdx, COPY_WORDS);
    @(negedge clk);
    chk(fastRstN == 1'b1, "R6 fast release one cycle later", fastRstN, 1);
    // R8: stray acknowledges after completion
    ackPoke = 1'b1;
    repeat (3) @(negedge clk);
    ackPoke = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(mirWe == 1'b0 && busReq == 1'b0, "R8 stray ack ignored", {mirWe, busReq}, 0);
      chk(copyDone == 1'b1 && fastRstN == 1'b1, "R5 done held", {copyDone, fastRstN}, 3);
    end
    chk(expIdx == COPY_WORDS, "R5 no extra writes", expIdx, COPY_WORDS);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(copyDone == 1'b0 && fastRstN == 1'b0 && origCpuRst == 1'b1, "R1 reset state",
        {copyDone, fastRstN, origCpuRst}, 1);
    runCopy(16'h1000, 16'h8000, 0);
    runCopy(16'h4000, 16'h0200, 1);
    runCopy(16'hFFFC, 16'hFFFA, 2);   // R9 wrap
    runCopy(16'h0000, 16'h0000, 2);

    // R7: reset in the middle of the copy
    srcBase = 16'h2100; dstBase = 16'h9100; latMode = 1;
    doReset();
    while (expIdx < 3) @(negedge clk);
    chk(copyDone == 1'b0, "R7 copy incomplete before reset", copyDone, 0);
    runCopy(16'h2100, 16'h9100, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule